// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the bus-facing protocol engine of a 256-byte serial memory that sits on a two-wire bus. It runs on a fast system clock. It resynchronizes the bus clock and data lines and finds start and stop conditions in them. It shifts in each byte on the rising edges of the bus clock. When it accepts a byte, it answers on the data line by pulling it low for the ninth clock.

A transfer begins with a control byte. The engine compares the top four bits of that byte with a fixed device code and ignores the three bits below them. The lowest bit selects the direction. For a write, the next byte is the word address, which is loaded into a pointer. Every byte after that goes to an external write buffer, together with its target address and a one-cycle strobe. After each such byte, the low bits of the pointer step forward and wrap within an 8-byte page. A stop that ends a write holding at least one data byte raises a commit pulse, and the write controller then starts programming. While the write controller reports busy, the engine does not answer its own control byte.

Top module: `twowire_mem_target`

## Requirements
- R1: After a start, a control byte whose bits 7..4 are 1010 and whose bit 0 is 0 is acknowledged while busy is low: sda_pull is 1 during the high phase of the ninth bus clock and is 0 again once that clock has fallen.
- R2: A control byte whose bits 7..4 differ from 1010 gets no acknowledge. Until the next start, the following bytes are neither acknowledged nor passed on, and no pointer load happens.
- R3: Bits 3..1 of the control byte take no part in matching. Any value of these bits is acknowledged when the device code matches.
- R4: While busy is high at the end of the control byte, that byte gets no acknowledge. The rest of the transfer is ignored, even if busy drops later in it.
- R5: In a write, the byte after the control byte is acknowledged, loaded into ptr_addr, and marked by a one-cycle ptr_load pulse.
- R6: Each later byte of a write is acknowledged and appears on wr_data, with a one-cycle wr_strobe. At the same time wr_addr shows the current pointer.
- R7: After each data byte, the pointer's bits 2..0 increment and wrap from 7 to 0, while bits 7..3 keep their value.
- R8: A control byte with bit 0 = 1 (read) and a matching code is acknowledged. After it, the engine neither acknowledges nor passes on any byte until the next start.
- R9: A stop raises one commit pulse if at least one data byte was passed on since the last start. Otherwise it raises none.
- R10: A stop or a repeated start inside a byte abandons that byte without a strobe. A repeated start clears pending data without a commit, and the engine is matching control bytes again at once.
- R11: After reset, sda_pull, ptr_load, wr_strobe and commit are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| busy | input | 1 | Write controller is programming the array |
| sda_pull | output | 1 | 1 pulls the open-drain data line low |
| ptr_load | output | 1 | One-cycle pulse when a word address is loaded |
| ptr_addr | output | 8 | Current address pointer |
| wr_strobe | output | 1 | One-cycle pulse when a data byte is passed on |
| wr_addr | output | 8 | Target address of the byte on wr_data |
| wr_data | output | 8 | Received data byte |
| commit | output | 1 | One-cycle pulse at a stop that ends a write holding data |

## Verification
On every cycle the assertions check the following: the three output pulses never coincide, an acknowledge only begins just after a bus clock falls, and no control byte is acknowledged while busy is high. They also check that a strobed address keeps the upper pointer bits and that commit only fires when the engine has returned to idle. The scenarios alone show which byte values match, the addresses and data that actually reach the write buffer, the page wrap, the one-commit-per-write rule, and the recovery after aborted bytes. All of these depend on complete bus sequences.

// File: rtl/twowire_mem_target.sv
module twowire_mem_target #(
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int AW = 8,
  parameter int PB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          busy,
  output logic          sda_pull,
  output logic          ptr_load,
  output logic [AW-1:0] ptr_addr,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit
);

  typedef enum logic [1:0] {ST_IDLE, ST_CTRL, ST_WADDR, ST_DATA} st_t;

  logic [2:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_s, sda_d;
  logic scl_rise, scl_fall, start_c, stop_c;
  st_t st;
  logic [3:0] bitcnt;
  logic ackp, dirty;
  logic [7:0] sh;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end

  assign scl_s    = scl_p[1];
  assign scl_d    = scl_p[2];
  assign sda_s    = sda_p[1];
  assign sda_d    = sda_p[2];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign ptr_addr = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE;
      bitcnt <= '0;
      ackp <= 1'b0;
      dirty <= 1'b0;
      sh <= '0;
      ptr <= '0;
      sda_pull <= 1'b0;
      ptr_load <= 1'b0;
      wr_strobe <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      commit <= 1'b0;
    end else begin
      ptr_load  <= 1'b0;
      wr_strobe <= 1'b0;
      commit    <= 1'b0;
      if (start_c) begin
        st <= ST_CTRL;
        bitcnt <= '0;
        ackp <= 1'b0;
        sda_pull <= 1'b0;
        dirty <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE;
        bitcnt <= '0;
        ackp <= 1'b0;
        sda_pull <= 1'b0;
        commit <= dirty;
        dirty <= 1'b0;
      end else if (scl_fall && ackp) begin
        ackp <= 1'b0;
        sda_pull <= 1'b0;
        bitcnt <= '0;
      end else if (st != ST_IDLE) begin
        if (scl_rise && bitcnt < 4'd8) begin
          sh <= {sh[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          case (st)
            ST_CTRL:
              if (sh[7:4] == DEV_CODE && !busy) begin
                ackp <= 1'b1;
                sda_pull <= 1'b1;
                st <= sh[0] ? ST_IDLE : ST_WADDR;
              end else begin
                st <= ST_IDLE;
              end
            ST_WADDR: begin
              ackp <= 1'b1;
              sda_pull <= 1'b1;
              ptr <= sh[AW-1:0];
              ptr_load <= 1'b1;
              st <= ST_DATA;
            end
            default: begin
              ackp <= 1'b1;
              sda_pull <= 1'b1;
              wr_strobe <= 1'b1;
              wr_data <= sh;
              wr_addr <= ptr;
              ptr <= {ptr[AW-1:PB], ptr[PB-1:0] + 1'b1};
              dirty <= 1'b1;
            end
          endcase
        end
      end
    end

  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ptr_load, wr_strobe, commit}));

  // R1
  ack_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  // R4
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && $past(st == ST_CTRL)) |-> !$past(busy));

  // R7
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> ptr[AW-1:PB] == wr_addr[AW-1:PB]);

  // R9
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> st == ST_IDLE);

endmodule

// File: tb/sim_twowire_mem_target.sv
module sim_twowire_mem_target;
  localparam int CLK_P = 10;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_pull, ptr_load, wr_strobe, commit;
  logic [7:0] ptr_addr, wr_addr, wr_data;
  logic sda_line;

  assign sda_line = sda_m & ~sda_pull;
  always #(CLK_P/2) clk = ~clk;

  twowire_mem_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .busy(busy),
    .sda_pull(sda_pull), .ptr_load(ptr_load), .ptr_addr(ptr_addr),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit)
  );

  int nchk = 0, nfail = 0;
  int nwr = 0, nld = 0, ncm = 0;
  logic [7:0] cap_a [16];
  logic [7:0] cap_d [16];
  logic [7:0] last_ld;

  always @(posedge clk) begin
    if (wr_strobe && nwr < 16) begin
      cap_a[nwr] <= wr_addr;
      cap_d[nwr] <= wr_data;
    end
    if (wr_strobe) nwr <= nwr + 1;
    if (ptr_load) begin nld <= nld + 1; last_ld <= ptr_addr; end
    if (commit) ncm <= ncm + 1;
  end

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    sda_m = 1'b0; wclk(H); scl = 1'b0; wclk(H);
  endtask

  task automatic b_restart();
    sda_m = 1'b1; wclk(H); scl = 1'b1; wclk(H); b_start();
  endtask

  task automatic b_stop();
    sda_m = 1'b0; wclk(H); scl = 1'b1; wclk(H); sda_m = 1'b1; wclk(H);
  endtask

  task automatic b_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wclk(H); scl = 1'b1; wclk(H); scl = 1'b0;
    end
  endtask

  task automatic b_byte(input logic [7:0] b, output logic ack);
    b_bits(b, 8);
    sda_m = 1'b1; wclk(H); scl = 1'b1; wclk(H/2);
    ack = sda_pull;
    wclk(H/2); scl = 1'b0; wclk(H);
  endtask

  localparam int NV = 9;
  localparam logic [9:0] VEC [NV] = '{
    {8'hA0, 1'b0, 1'b1}, {8'hA2, 1'b0, 1'b1}, {8'hAE, 1'b0, 1'b1},
    {8'hAC, 1'b0, 1'b1}, {8'hA1, 1'b0, 1'b1}, {8'hB0, 1'b0, 1'b0},
    {8'h20, 1'b0, 1'b0}, {8'hE0, 1'b0, 1'b0}, {8'hA0, 1'b1, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic a;
    wclk(5);
    // R11
    chk("R11 sda_pull", sda_pull, 0);
    chk("R11 pulses", {ptr_load, wr_strobe, commit}, 0);
    rst_n = 1'b1;
    wclk(5);

    for (int v = 0; v < NV; v++) begin
      busy = VEC[v][1];
      b_start();
      b_byte(VEC[v][9:2], a);
      // R1 R2 R3 R4 R8
      chk("R1/R2/R3/R4 ctrl ack", a, VEC[v][0]);
      chk("R1 release", sda_pull, 0);
      b_stop();
      busy = 1'b0;
    end
    chk("R9 no commit w/o data", ncm, 0);
    chk("R5 no load in vectors", nld, 0);

    b_start();
    b_byte(8'hA4, a); chk("R1 ack", a, 1);
    b_byte(8'h3D, a); chk("R5 addr ack", a, 1);
    chk("R5 ptr_load", nld, 1);
    chk("R5 ptr value", last_ld, 8'h3D);
    b_byte(8'h11, a); chk("R6 ack", a, 1);
    b_byte(8'h22, a); b_byte(8'h33, a); b_byte(8'h44, a);
    chk("R6 ack last", a, 1);
    b_stop();
    chk("R6 strobes", nwr, 4);
    chk("R6 data0", cap_d[0], 8'h11);
    chk("R6 data3", cap_d[3], 8'h44);
    chk("R6 addr0", cap_a[0], 8'h3D);
    chk("R7 addr2", cap_a[2], 8'h3F);
    chk("R7 wrap", cap_a[3], 8'h38);
    chk("R7 ptr after", ptr_addr, 8'h39);
    chk("R9 commit", ncm, 1);

    b_start();
    b_byte(8'hA1, a); chk("R8 read ack", a, 1);
    b_byte(8'h55, a); chk("R8 no ack after read", a, 0);
    b_stop();
    chk("R8 no strobe", nwr, 4);
    chk("R9 no commit read", ncm, 1);

    busy = 1'b1;
    b_start();
    b_byte(8'hA0, a); chk("R4 busy no ack", a, 0);
    busy = 1'b0;
    b_byte(8'h12, a); chk("R4 rest ignored", a, 0);
    b_byte(8'h34, a);
    b_stop();
    chk("R4 no load", nld, 1);
    chk("R4 no strobe", nwr, 4);

    b_start();
    b_byte(8'h90, a); chk("R2 mismatch", a, 0);
    b_byte(8'h00, a); chk("R2 next ignored", a, 0);
    b_byte(8'h66, a);
    b_stop();
    chk("R2 no load", nld, 1);
    chk("R2 no strobe", nwr, 4);

    b_start();
    b_byte(8'hA0, a); b_byte(8'h10, a);
    b_bits(8'hFF, 3);
    b_stop();
    chk("R10 stop mid-byte no strobe", nwr, 4);
    chk("R10 no commit", ncm, 1);

    b_start();
    b_byte(8'hA0, a); b_byte(8'h20, a); b_byte(8'h99, a);
    b_bits(8'h0F, 5);
    b_restart();
    chk("R10 partial dropped", nwr, 5);
    b_byte(8'hA0, a); chk("R10 match after restart", a, 1);
    b_byte(8'h50, a); b_byte(8'h77, a);
    b_stop();
    chk("R10 new write", nwr, 6);
    chk("R10 new addr", cap_a[5], 8'h50);
    chk("R10 new data", cap_d[5], 8'h77);
    chk("R10 one commit", ncm, 2);
    chk("R11 idle line", sda_pull, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule